// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block decodes every access from an 8-bit controller core or its DMA engine. Each access names one of two 64 KB address spaces, a data space (XDATA) and an instruction space (CODE). The decoder sends it to exactly one physical target: on-chip SRAM, the extended register block, the special function register mirror, the read-only information page, or one 32 KB bank of a flash array of up to 256 KB. Decoding is combinational. The block drives one chip select per target, a local offset inside the target, an 18-bit physical flash address and a write enable that is already gated by write permission. It returns read data from the selected target's read port with no added latency.

Two small configuration registers control the mapping. The data-space register holds the bank shown in the upper XDATA half and an overlay enable. The overlay enable places SRAM at the bottom of the CODE bank window. The code-space register holds the bank shown in the upper CODE half. Both registers change only through a dedicated write strobe. A new value applies to accesses from the next cycle onward. Banks that do not exist, address holes and builds with no bankable flash all read as zero and raise no select.

Top module: `bank_mapper`

## Requirements
- R1: In XDATA, addresses 0 to SRAM_SIZE-1 select SRAM with offset equal to the address. Writes there assert we_o. With the default SRAM_SIZE of 8192, 0x2000 is no longer SRAM.
- R2: XDATA 0x6000 to 0x63FF selects the extended register block with offset addr[9:0]. Writes there assert we_o.
- R3: XDATA 0x7080 to 0x70FF selects the register mirror with offset addr[7:0] (0x80 to 0xFF). 0x707F and 0x7100 do not select it.
- R4: XDATA 0x7800 to 0x7FFF selects the information page with offset addr[10:0]. A write there leaves we_o low.
- R5: XDATA 0x8000 to 0xFFFF selects flash. The bank comes from data-space register bits [2:0], and flash_addr_o = {bank, addr[14:0]}. Writes leave we_o low.
- R6: CODE 0x0000 to 0x7FFF always selects flash bank 0. No write in CODE space ever asserts we_o.
- R7: CODE 0x8000 to 0xFFFF selects the flash bank held in the code-space register, bits [2:0].
- R8: When data-space register bit 3 (overlay) is set, CODE 0x8000 to 0x8000+SRAM_SIZE-1 selects SRAM with offset addr[14:0]. The rest of the window stays on the code-space bank.
- R9: With FLASH_KB = 32, CODE 0x8000 to 0xFFFF without overlay raises no select and returns 0x00.
- R10: A bank number at or above FLASH_KB/32 raises no select and returns 0x00.
- R11: Unmapped XDATA addresses raise no select, return 0x00 and never assert we_o.
- R12: Both registers reset to 0. A write is cfg_we_i with cfg_sel_i = 0 for the data-space register or 1 for the code-space register, data on cfg_wdata_i. The access in the same cycle still sees the old value, and the next cycle sees the new one.
- R13: At most one select is high, and none while req_i is low. rdata_o is the selected target's read data in the same cycle, or 0x00 if no target is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access valid |
| space_i | input | 1 | 0 = XDATA, 1 = CODE |
| addr_i | input | 16 | Access address |
| we_i | input | 1 | Access is a write |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 1 | 0 = data-space register, 1 = code-space register |
| cfg_wdata_i | input | 4 | [3] overlay enable, [2:0] bank |
| sram_rdata_i | input | 8 | SRAM read data |
| xreg_rdata_i | input | 8 | Extended register read data |
| sfr_rdata_i | input | 8 | Register mirror read data |
| info_rdata_i | input | 8 | Information page read data |
| flash_rdata_i | input | 8 | Flash read data |
| sram_cs_o | output | 1 | SRAM select |
| xreg_cs_o | output | 1 | Extended register select |
| sfr_cs_o | output | 1 | Register mirror select |
| info_cs_o | output | 1 | Information page select |
| flash_cs_o | output | 1 | Flash select |
| we_o | output | 1 | Write enable to the selected writable target |
| local_addr_o | output | 15 | Offset inside the selected target |
| flash_addr_o | output | 18 | Physical flash address |
| rdata_o | output | 8 | Read data returned to the requester |

## Verification
The two cases that are hardest to reach from the ports are the zero-return paths for missing flash. The default build has eight banks, so no register value can ever name a bank that does not exist. The bench therefore drives the same stimulus into two more instances: one sized at 32 KB, which has no bankable flash, and one sized at 96 KB, which has three banks. On those instances a bank value of 5 and the upper CODE half must come back empty while the lower half still works. The register timing is also checked inside a single cycle. The bench samples once before the clock edge that captures the write and once after it, with the same address held, to show the old mapping and then the new one.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_SRAM  = 3'd1,
    TGT_XREG  = 3'd2,
    TGT_SFR   = 3'd3,
    TGT_INFO  = 3'd4,
    TGT_FLASH = 3'd5
  } tgt_e;

  localparam int NUM_TGT = 5;  // select order: sram, xreg, sfr, info, flash
  localparam int BANK_W  = 3;
  localparam int OFF_W   = 15;
endpackage

// File: rtl/bm_cfg_regs.sv
module bm_cfg_regs
  import bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [3:0]        cfg_wdata_i,
  output logic [BANK_W-1:0] xbank_o,
  output logic              overlay_o,
  output logic [BANK_W-1:0] cbank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xbank_o   <= '0;
      overlay_o <= 1'b0;
      cbank_o   <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) begin
        cbank_o <= cfg_wdata_i[BANK_W-1:0];
      end else begin
        xbank_o   <= cfg_wdata_i[BANK_W-1:0];
        overlay_o <= cfg_wdata_i[3];
      end
    end
  end

  a_r12_cbank_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i |=> cbank_o == $past(cfg_wdata_i[BANK_W-1:0]));
  a_r12_xreg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i |=> $stable(xbank_o) && $stable(overlay_o));
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cbank_o) && $stable(xbank_o));
endmodule

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
#(
  parameter int SRAM_SIZE = 8192,
  parameter int NUM_BANKS = 8
) (
  input  logic              space_i,
  input  logic [15:0]       addr_i,
  input  logic [BANK_W-1:0] xbank_i,
  input  logic              overlay_i,
  input  logic [BANK_W-1:0] cbank_i,
  output tgt_e              tgt_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [16:0] SRAM_LIM = 17'(SRAM_SIZE);
  localparam logic [3:0]  NB       = 4'(NUM_BANKS);
  localparam bit          BANKABLE = NUM_BANKS > 1;

  logic x_sram, x_xreg, x_sfr, x_info, c_ovl;
  logic xbank_ok, cbank_ok;

  assign x_sram   = {1'b0, addr_i} < SRAM_LIM;
  assign x_xreg   = addr_i[15:10] == 6'b011000;
  assign x_sfr    = addr_i[15:7] == 9'b0111_0000_1;
  assign x_info   = addr_i[15:11] == 5'b01111;
  assign c_ovl    = overlay_i && ({2'b00, addr_i[14:0]} < SRAM_LIM);
  assign xbank_ok = {1'b0, xbank_i} < NB;
  assign cbank_ok = BANKABLE && ({1'b0, cbank_i} < NB);

  always_comb begin
    tgt_o  = TGT_NONE;
    off_o  = addr_i[14:0];
    bank_o = '0;
    if (!space_i) begin
      if (addr_i[15]) begin
        bank_o = xbank_i;
        if (xbank_ok) tgt_o = TGT_FLASH;
      end else if (x_sram) begin
        tgt_o = TGT_SRAM;
      end else if (x_xreg) begin
        tgt_o = TGT_XREG;
        off_o = {5'd0, addr_i[9:0]};
      end else if (x_sfr) begin
        tgt_o = TGT_SFR;
        off_o = {7'd0, addr_i[7:0]};
      end else if (x_info) begin
        tgt_o = TGT_INFO;
        off_o = {4'd0, addr_i[10:0]};
      end
    end else begin
      if (!addr_i[15]) begin
        tgt_o = TGT_FLASH;  // common half: bank 0
      end else if (c_ovl) begin
        tgt_o = TGT_SRAM;
      end else begin
        bank_o = cbank_i;
        if (cbank_ok) tgt_o = TGT_FLASH;
      end
    end
  end
endmodule

// File: rtl/bm_rdata_mux.sv
module bm_rdata_mux
  import bm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NUM_TGT-1:0]         cs_i,
  input  logic [NUM_TGT-1:0][DW-1:0] rdata_i,
  output logic [DW-1:0]              rdata_o
);
  logic [NUM_TGT-1:0][DW-1:0] masked;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_mask
    assign masked[g] = rdata_i[g] & {DW{cs_i[g]}};
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TGT; i++) rdata_o |= masked[i];
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bm_pkg::*;
#(
  parameter int SRAM_SIZE = 8192,
  parameter int FLASH_KB  = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        space_i,
  input  logic [15:0] addr_i,
  input  logic        we_i,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [3:0]  cfg_wdata_i,
  input  logic [7:0]  sram_rdata_i,
  input  logic [7:0]  xreg_rdata_i,
  input  logic [7:0]  sfr_rdata_i,
  input  logic [7:0]  info_rdata_i,
  input  logic [7:0]  flash_rdata_i,
  output logic        sram_cs_o,
  output logic        xreg_cs_o,
  output logic        sfr_cs_o,
  output logic        info_cs_o,
  output logic        flash_cs_o,
  output logic        we_o,
  output logic [14:0] local_addr_o,
  output logic [17:0] flash_addr_o,
  output logic [7:0]  rdata_o
);
  localparam int NUM_BANKS = FLASH_KB / 32;

  logic [BANK_W-1:0] xbank, cbank, bank;
  logic              overlay;
  tgt_e              tgt;
  logic [OFF_W-1:0]  off;
  logic [NUM_TGT-1:0] cs;

  bm_cfg_regs u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .xbank_o(xbank), .overlay_o(overlay), .cbank_o(cbank)
  );

  bm_decode #(.SRAM_SIZE(SRAM_SIZE), .NUM_BANKS(NUM_BANKS)) u_dec (
    .space_i, .addr_i, .xbank_i(xbank), .overlay_i(overlay), .cbank_i(cbank),
    .tgt_o(tgt), .off_o(off), .bank_o(bank)
  );

  assign cs[0] = req_i && tgt == TGT_SRAM;
  assign cs[1] = req_i && tgt == TGT_XREG;
  assign cs[2] = req_i && tgt == TGT_SFR;
  assign cs[3] = req_i && tgt == TGT_INFO;
  assign cs[4] = req_i && tgt == TGT_FLASH;

  assign {flash_cs_o, info_cs_o, sfr_cs_o, xreg_cs_o, sram_cs_o} = cs;
  assign we_o         = we_i && !space_i && |cs[2:0];
  assign local_addr_o = off;
  assign flash_addr_o = {bank, off};

  bm_rdata_mux #(.DW(8)) u_mux (
    .cs_i(cs),
    .rdata_i({flash_rdata_i, info_rdata_i, sfr_rdata_i, xreg_rdata_i, sram_rdata_i}),
    .rdata_o
  );

  a_r13_onehot_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flash_cs_o, info_cs_o, sfr_cs_o, xreg_cs_o, sram_cs_o}));
  a_r13_idle_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(flash_cs_o || info_cs_o || sfr_cs_o || xreg_cs_o || sram_cs_o));
  a_r11_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_cs_o || info_cs_o || sfr_cs_o || xreg_cs_o || sram_cs_o) |-> rdata_o == 8'h00);
  a_r4_info_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    info_cs_o |-> !we_o);
  a_r5_flash_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_cs_o |-> !we_o);
  a_r6_code_low_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && space_i && !addr_i[15] |-> flash_cs_o && flash_addr_o[17:15] == 3'd0);
endmodule

// File: tb/bank_mapper_tb_top.sv
module bm_tb_stub (
  input  logic [14:0] local_i,
  input  logic [17:0] faddr_i,
  output logic [7:0]  sram_o,
  output logic [7:0]  xreg_o,
  output logic [7:0]  sfr_o,
  output logic [7:0]  info_o,
  output logic [7:0]  flash_o
);
  assign sram_o  = {4'h1, local_i[3:0]};
  assign xreg_o  = {4'h2, local_i[3:0]};
  assign sfr_o   = {4'h3, local_i[3:0]};
  assign info_o  = {4'h4, local_i[3:0]};
  assign flash_o = {1'b1, faddr_i[17:15], faddr_i[3:0]};
endmodule

module bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, space = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0] cfg_wd = '0;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // three builds: 0 = 256 KB, 1 = 32 KB, 2 = 96 KB
  logic [2:0][4:0]  cs;
  logic [2:0]       wo;
  logic [2:0][14:0] loc;
  logic [2:0][17:0] fa;
  logic [2:0][7:0]  rd, s_rd, x_rd, f_rd, i_rd, fl_rd;

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam int FK = (g == 0) ? 256 : (g == 1) ? 32 : 96;
    bm_tb_stub u_stub (
      .local_i(loc[g]), .faddr_i(fa[g]), .sram_o(s_rd[g]), .xreg_o(x_rd[g]),
      .sfr_o(f_rd[g]), .info_o(i_rd[g]), .flash_o(fl_rd[g])
    );
    if (g == 0) begin : g_main
      bank_mapper #(.SRAM_SIZE(8192), .FLASH_KB(FK)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .space_i(space), .addr_i(addr),
        .we_i(we), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
        .sram_rdata_i(s_rd[g]), .xreg_rdata_i(x_rd[g]), .sfr_rdata_i(f_rd[g]),
        .info_rdata_i(i_rd[g]), .flash_rdata_i(fl_rd[g]),
        .sram_cs_o(cs[g][0]), .xreg_cs_o(cs[g][1]), .sfr_cs_o(cs[g][2]),
        .info_cs_o(cs[g][3]), .flash_cs_o(cs[g][4]), .we_o(wo[g]),
        .local_addr_o(loc[g]), .flash_addr_o(fa[g]), .rdata_o(rd[g])
      );
    end else begin : g_alt
      bank_mapper #(.SRAM_SIZE(8192), .FLASH_KB(FK)) alt_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .space_i(space), .addr_i(addr),
        .we_i(we), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
        .sram_rdata_i(s_rd[g]), .xreg_rdata_i(x_rd[g]), .sfr_rdata_i(f_rd[g]),
        .info_rdata_i(i_rd[g]), .flash_rdata_i(fl_rd[g]),
        .sram_cs_o(cs[g][0]), .xreg_cs_o(cs[g][1]), .sfr_cs_o(cs[g][2]),
        .info_cs_o(cs[g][3]), .flash_cs_o(cs[g][4]), .we_o(wo[g]),
        .local_addr_o(loc[g]), .flash_addr_o(fa[g]), .rdata_o(rd[g])
      );
    end
  end

  task automatic check(input string rq, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", rq, what, got, exp);
    end
  endtask

  task automatic access(input logic sp, input logic [15:0] a, input logic w);
    @(negedge clk);
    req = 1'b1; space = sp; addr = a; we = w;
    #1;
  endtask

  task automatic wr_cfg(input logic sel, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wd = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // {req_no, space, addr, we, exp cs {flash,info,sfr,xreg,sram}, exp we, exp rdata}
  localparam int NV = 22;
  localparam logic [NV-1:0][39:0] VEC = {
    {8'd1,  1'b0, 16'h0005, 1'b0, 5'b00001, 1'b0, 8'h15},  // R1
    {8'd1,  1'b0, 16'h1FFF, 1'b0, 5'b00001, 1'b0, 8'h1F},  // R1 top
    {8'd1,  1'b0, 16'h0003, 1'b1, 5'b00001, 1'b1, 8'h13},  // R1 write
    {8'd11, 1'b0, 16'h2000, 1'b0, 5'b00000, 1'b0, 8'h00},  // R11
    {8'd11, 1'b0, 16'h2000, 1'b1, 5'b00000, 1'b0, 8'h00},  // R11 write
    {8'd2,  1'b0, 16'h6007, 1'b0, 5'b00010, 1'b0, 8'h27},  // R2
    {8'd2,  1'b0, 16'h63FF, 1'b0, 5'b00010, 1'b0, 8'h2F},  // R2 top
    {8'd2,  1'b0, 16'h6000, 1'b1, 5'b00010, 1'b1, 8'h20},  // R2 write
    {8'd11, 1'b0, 16'h6400, 1'b0, 5'b00000, 1'b0, 8'h00},  // R11
    {8'd3,  1'b0, 16'h7080, 1'b0, 5'b00100, 1'b0, 8'h30},  // R3
    {8'd3,  1'b0, 16'h70FF, 1'b0, 5'b00100, 1'b0, 8'h3F},  // R3 top
    {8'd3,  1'b0, 16'h707F, 1'b0, 5'b00000, 1'b0, 8'h00},  // R3 below
    {8'd3,  1'b0, 16'h7100, 1'b0, 5'b00000, 1'b0, 8'h00},  // R3 above
    {8'd4,  1'b0, 16'h7801, 1'b0, 5'b01000, 1'b0, 8'h41},  // R4
    {8'd4,  1'b0, 16'h7FFE, 1'b1, 5'b01000, 1'b0, 8'h4E},  // R4 write ignored
    {8'd5,  1'b0, 16'h8006, 1'b0, 5'b10000, 1'b0, 8'hA6},  // R5 bank 2
    {8'd5,  1'b0, 16'hFFFF, 1'b1, 5'b10000, 1'b0, 8'hAF},  // R5 write ignored
    {8'd6,  1'b1, 16'h0009, 1'b0, 5'b10000, 1'b0, 8'h89},  // R6
    {8'd6,  1'b1, 16'h7FFF, 1'b0, 5'b10000, 1'b0, 8'h8F},  // R6 top
    {8'd6,  1'b1, 16'h0002, 1'b1, 5'b10000, 1'b0, 8'h82},  // R6 write ignored
    {8'd7,  1'b1, 16'h8001, 1'b0, 5'b10000, 1'b0, 8'hD1},  // R7 bank 5
    {8'd7,  1'b1, 16'hFFF3, 1'b0, 5'b10000, 1'b0, 8'hD3}   // R7
  };

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13: no request, no select
    #1;
    check("R13", "cs idle", {27'd0, cs[0]}, 32'd0);
    check("R13", "rdata idle", {24'd0, rd[0]}, 32'h00);

    // R12: reset banks are 0, overlay off
    access(1'b1, 16'h8003, 1'b0);
    check("R12", "code bank reset", {24'd0, rd[0]}, 32'h83);
    check("R12", "code cs reset", {27'd0, cs[0]}, 32'h10);
    access(1'b0, 16'h8004, 1'b0);
    check("R12", "xdata bank reset", {24'd0, rd[0]}, 32'h84);

    wr_cfg(1'b0, 4'h2);
    wr_cfg(1'b1, 4'h5);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string rq;
      v = VEC[NV-1-i];
      rq = $sformatf("R%0d", v[39:32]);
      access(v[31], v[30:15], v[14]);
      check(rq, $sformatf("cs @%h", v[30:15]), {27'd0, cs[0]}, {27'd0, v[13:9]});
      check(rq, $sformatf("we @%h", v[30:15]), {31'd0, wo[0]}, {31'd0, v[8]});
      check(rq, $sformatf("rdata @%h", v[30:15]), {24'd0, rd[0]}, {24'd0, v[7:0]});
    end

    // R5/R7: physical flash address
    access(1'b1, 16'h8001, 1'b0);
    check("R7", "flash addr", {14'd0, fa[0]}, 32'h28001);
    access(1'b0, 16'hC123, 1'b0);
    check("R5", "flash addr", {14'd0, fa[0]}, 32'h14123);

    // R9: 32 KB build has no bankable flash
    access(1'b1, 16'h8001, 1'b0);
    check("R9", "32k upper rdata", {24'd0, rd[1]}, 32'h00);
    check("R9", "32k upper cs", {27'd0, cs[1]}, 32'h00);
    access(1'b1, 16'h0001, 1'b0);
    check("R9", "32k lower rdata", {24'd0, rd[1]}, 32'h81);

    // R10: 96 KB build, code bank 5 missing, xdata bank 2 present
    access(1'b1, 16'h8001, 1'b0);
    check("R10", "bank5 of 3 rdata", {24'd0, rd[2]}, 32'h00);
    check("R10", "bank5 of 3 cs", {27'd0, cs[2]}, 32'h00);
    access(1'b0, 16'h8006, 1'b0);
    check("R10", "bank2 of 3 rdata", {24'd0, rd[2]}, 32'hA6);

    // R12 + R8: overlay write seen only after the capturing edge
    access(1'b1, 16'h8005, 1'b0);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wd = 4'hA;
    #1;
    check("R12", "old map same cycle", {24'd0, rd[0]}, 32'hD5);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R8", "overlay sram", {24'd0, rd[0]}, 32'h15);
    check("R8", "overlay cs", {27'd0, cs[0]}, 32'h01);
    check("R8", "overlay local", {17'd0, loc[0]}, 32'h0005);
    access(1'b1, 16'h9FFF, 1'b1);
    check("R8", "overlay top", {24'd0, rd[0]}, 32'h1F);
    check("R6", "code write ignored", {31'd0, wo[0]}, 32'd0);
    access(1'b1, 16'hA000, 1'b0);
    check("R8", "past overlay", {24'd0, rd[0]}, 32'hD0);
    access(1'b0, 16'h8006, 1'b0);
    check("R12", "xbank kept", {24'd0, rd[0]}, 32'hA6);

    // R13: dropping request clears selects
    @(negedge clk);
    req = 1'b0;
    #1;
    check("R13", "cs after drop", {27'd0, cs[0]}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule